// File: doc/BRIEF.md
# SDRAM Scanline Read Sequencer

This block produces the SDRAM command stream and the panel data-enable needed to scan a frame buffer straight onto a TFT panel. The panel takes only a dot clock, a data-enable strobe and colour bits, and it has no sync inputs. The SDRAM data pins drive the panel colour inputs directly. The sequencer therefore only has to place the panel enable so that it covers the cycles in which the burst data is valid. It does this by timing the enable from the read command and the CAS latency.

Each visible line opens one row and starts a full-page burst at column 0. It then holds NOPs while the panel takes one pixel per clock, stops the burst and closes the row. A fixed number of auto-refreshes follows before the next line. After the last visible line the sequencer grants the SDRAM bus to an external write engine for a blanking window of a whole number of line times. It takes the bus back only once the writer has released it. The frame's first row comes from a base input, so changing that base selects another stored page or scrolls the picture by whole lines.

Top module: `scan_rd_seq`

## Requirements
- R1: Commands on {cs_n, ras_n, cas_n, we_n} use the codes NOP=0111, ACTIVATE=0011, READ=0101, BURST-STOP=0110, PRECHARGE=0010, REFRESH=0001. Every cycle with no other command due carries NOP. While reset is high the outputs are NOP, dqm high, den low, grant low, frame_start low and cke high.
- R2: A visible line begins with ACTIVATE, with addr set to the row and ba set to the bank. T_RCD cycles later comes READ, with addr all zero (column 0 and auto-precharge bit 10 low) and the same bank.
- R3: pnl_den rises exactly CAS_LAT cycles after the READ cycle and stays high for exactly ACTIVE_W cycles.
- R4: BURST-STOP is issued ACTIVE_W cycles after READ. PRECHARGE follows in the very next cycle with addr bit 10 high (all banks) and every other address bit low.
- R5: The first REFRESH comes T_RP cycles after PRECHARGE. There are exactly N_REF REFRESH commands, each T_RFC cycles after the previous one. The next line's ACTIVATE comes T_RFC cycles after the last REFRESH.
- R6: Line n of a frame uses page-row base+n, taken modulo 2^(BANK_W+ADDR_W). Its low ADDR_W bits go out on addr and its upper BANK_W bits go out on ba.
- R7: base_row is sampled only on the clock edge that starts a frame: the edges during reset and the edge that leaves the reclaim cycle. A change at any other time has no effect on the current frame.
- R8: After VIS_LINES lines, wr_grant is high for exactly BLANK_LINES line times. During that window the sequencer drives only NOP with dqm high, and line_no reads VIS_LINES.
- R9: When the window ends, wr_grant falls and NOPs follow for as long as wr_ack is high. The next frame's ACTIVATE comes in the cycle after the first cycle with wr_grant low and wr_ack low. wr_ack has no effect at any other time.
- R10: frame_start is high for exactly one cycle, the ACTIVATE cycle of line 0. During visible lines line_no gives the index of the current line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and SDRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| base_row | input | BANK_W+ADDR_W | First page-row of the frame, {bank,row} |
| wr_ack | input | 1 | Writer still holds the SDRAM bus |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_dqm | output | 1 | SDRAM data mask |
| sd_addr | output | ADDR_W | SDRAM address |
| sd_ba | output | BANK_W | SDRAM bank select |
| pnl_den | output | 1 | Panel data enable |
| wr_grant | output | 1 | Bus granted to the write engine |
| frame_start | output | 1 | One-cycle pulse at the start of a frame |
| line_no | output | $clog2(VIS_LINES+1) | Current visible line, VIS_LINES while blanking |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a base_row change and the frame-entry edge that samples it. The bench changes the base while wr_grant is falling, in the frame_start cycle itself, and in the middle of a frame. It then judges the ACTIVATE addresses of the following frames against an arithmetic model of which edge latched which base. The second pair is the end of the grant window and a writer that still holds wr_ack. Frames are run with wr_ack released anywhere from zero to several cycles after wr_grant falls, and with ack pulses inside the window. A cycle-accurate model predicts the reclaim length and the exact restart cycle.

// File: rtl/scan_rd_pkg.sv
package scan_rd_pkg;

    typedef enum logic [2:0] {
        C_NOP, C_ACT, C_RD, C_BST, C_PRE, C_REF
    } cmd_e;

    typedef enum logic [3:0] {
        S_ACT, S_RCD, S_READ, S_BURST, S_BST, S_PRE,
        S_RP, S_REF, S_RFC, S_GRANT, S_RECL
    } state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    localparam pins_t PINS_NOP = 4'b0111;

    function automatic pins_t cmd_pins(cmd_e c);
        case (c)
            C_ACT:   return 4'b0011;
            C_RD:    return 4'b0101;
            C_BST:   return 4'b0110;
            C_PRE:   return 4'b0010;
            C_REF:   return 4'b0001;
            default: return PINS_NOP;
        endcase
    endfunction

    // cycles from one line's ACTIVATE to the next one's
    function automatic int line_cycles(int w, int rcd, int rp, int rfc, int nref);
        return rcd + w + 1 + rp + nref * rfc;
    endfunction

endpackage

// File: rtl/scan_rd_fsm.sv
module scan_rd_fsm
    import scan_rd_pkg::*;
#(
    parameter int ACTIVE_W    = 800,
    parameter int VIS_LINES   = 480,
    parameter int BLANK_LINES = 100,
    parameter int T_RCD       = 2,
    parameter int T_RP        = 2,
    parameter int T_RFC       = 7,
    parameter int N_REF       = 4,
    parameter int ADDR_W      = 13,
    parameter int BANK_W      = 2,
    localparam int PG_W       = BANK_W + ADDR_W,
    localparam int LINE_W     = $clog2(VIS_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PG_W-1:0]   base_row,
    input  logic              wr_ack,
    output cmd_e              cmd,
    output logic [ADDR_W-1:0] row,
    output logic [BANK_W-1:0] bank,
    output logic              grant,
    output logic              dqm,
    output logic              frame_start,
    output logic [LINE_W-1:0] line_no
);

    localparam int LINE_CYC  = line_cycles(ACTIVE_W, T_RCD, T_RP, T_RFC, N_REF);
    localparam int BLANK_CYC = BLANK_LINES * LINE_CYC;
    localparam int CNT_W     = $clog2(BLANK_CYC + 1);
    localparam int REF_W     = (N_REF > 1) ? $clog2(N_REF) : 1;

    state_e            st;
    logic [CNT_W-1:0]  cnt;
    logic [REF_W-1:0]  ref_n;
    logic [LINE_W-1:0] line;
    logic [PG_W-1:0]   base_q;
    logic [PG_W-1:0]   cur_pg;

    initial begin
        if (T_RCD < 2 || T_RP < 2 || T_RFC < 2 || ACTIVE_W < 2 || N_REF < 1 ||
            VIS_LINES < 1 || BLANK_LINES < 1)
            $error("scan_rd_fsm: parameter out of range");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_ACT;
            cnt    <= '0;
            ref_n  <= '0;
            line   <= '0;
            base_q <= base_row;
        end else begin
            case (st)
                S_ACT: begin
                    st  <= S_RCD;
                    cnt <= CNT_W'(T_RCD - 2);
                end
                S_RCD: begin
                    if (cnt == '0) st <= S_READ;
                    else cnt <= cnt - 1'b1;
                end
                S_READ: begin
                    st  <= S_BURST;
                    cnt <= CNT_W'(ACTIVE_W - 2);
                end
                S_BURST: begin
                    if (cnt == '0) st <= S_BST;
                    else cnt <= cnt - 1'b1;
                end
                S_BST: st <= S_PRE;
                S_PRE: begin
                    st  <= S_RP;
                    cnt <= CNT_W'(T_RP - 2);
                end
                S_RP: begin
                    if (cnt == '0) begin
                        st    <= S_REF;
                        ref_n <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_REF: begin
                    st  <= S_RFC;
                    cnt <= CNT_W'(T_RFC - 2);
                end
                S_RFC: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (ref_n != REF_W'(N_REF - 1)) begin
                        st    <= S_REF;
                        ref_n <= ref_n + 1'b1;
                    end else if (line == LINE_W'(VIS_LINES - 1)) begin
                        st   <= S_GRANT;
                        line <= LINE_W'(VIS_LINES);
                        cnt  <= CNT_W'(BLANK_CYC - 1);
                    end else begin
                        st   <= S_ACT;
                        line <= line + 1'b1;
                    end
                end
                S_GRANT: begin
                    if (cnt == '0) st <= S_RECL;
                    else cnt <= cnt - 1'b1;
                end
                S_RECL: begin
                    if (!wr_ack) begin
                        st     <= S_ACT;
                        line   <= '0;
                        base_q <= base_row;
                    end
                end
                default: st <= S_ACT;
            endcase
        end
    end

    always_comb begin
        cmd = C_NOP;
        if (!rst) begin
            case (st)
                S_ACT:   cmd = C_ACT;
                S_READ:  cmd = C_RD;
                S_BST:   cmd = C_BST;
                S_PRE:   cmd = C_PRE;
                S_REF:   cmd = C_REF;
                default: cmd = C_NOP;
            endcase
        end
    end

    assign cur_pg      = base_q + PG_W'(line);
    assign row         = cur_pg[ADDR_W-1:0];
    assign bank        = cur_pg[PG_W-1:ADDR_W];
    assign grant       = !rst && (st == S_GRANT);
    assign dqm         = rst || (st == S_GRANT) || (st == S_RECL);
    assign frame_start = !rst && (st == S_ACT) && (line == '0);
    assign line_no     = line;

    a_r4_stop_then_close: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_BST) |=> (cmd == C_PRE));

    a_r9_hold_while_ack: assert property (@(posedge clk) disable iff (rst)
        ((st == S_RECL) && wr_ack) |=> ((cmd == C_NOP) && !grant));

    a_r5_refresh_after_stop: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_REF) |-> (line < LINE_W'(VIS_LINES)));

endmodule

// File: rtl/scan_rd_den.sv
module scan_rd_den #(
    parameter int ACTIVE_W = 800,
    parameter int CAS_LAT  = 2,
    localparam int W_W     = $clog2(ACTIVE_W + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_pulse,
    output logic den
);

    logic [CAS_LAT-1:0] lat_sr;
    logic [W_W-1:0]     run;

    generate
        if (CAS_LAT == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (rst) lat_sr <= '0;
                else     lat_sr <= rd_pulse;
            end
        end else begin : g_latn
            always_ff @(posedge clk) begin
                if (rst) lat_sr <= '0;
                else     lat_sr <= {lat_sr[CAS_LAT-2:0], rd_pulse};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (lat_sr[CAS_LAT-1]) begin
            run <= W_W'(ACTIVE_W - 1);
        end else if (run != '0) begin
            run <= run - 1'b1;
        end
    end

    assign den = lat_sr[CAS_LAT-1] || (run != '0);

    a_r3_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        lat_sr[CAS_LAT-1] |-> (run == '0));

endmodule

// File: rtl/scan_rd_enc.sv
module scan_rd_enc
    import scan_rd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    localparam int AP_BIT = 10
) (
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] row,
    input  logic [BANK_W-1:0] bank,
    output pins_t             pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);

    initial begin
        if (ADDR_W <= AP_BIT) $error("scan_rd_enc: address too narrow for bit 10");
    end

    always_comb begin
        pins = cmd_pins(cmd);
        addr = '0;
        ba   = '0;
        case (cmd)
            C_ACT: begin
                addr = row;
                ba   = bank;
            end
            C_RD: begin
                ba = bank;
            end
            C_PRE: begin
                addr[AP_BIT] = 1'b1;
                ba           = bank;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scan_rd_seq.sv
module scan_rd_seq
    import scan_rd_pkg::*;
#(
    parameter int ACTIVE_W    = 800,
    parameter int VIS_LINES   = 480,
    parameter int BLANK_LINES = 100,
    parameter int CAS_LAT     = 2,
    parameter int T_RCD       = 2,
    parameter int T_RP        = 2,
    parameter int T_RFC       = 7,
    parameter int N_REF       = 4,
    parameter int ADDR_W      = 13,
    parameter int BANK_W      = 2,
    localparam int PG_W       = BANK_W + ADDR_W,
    localparam int LINE_W     = $clog2(VIS_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PG_W-1:0]   base_row,
    input  logic              wr_ack,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_dqm,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic              pnl_den,
    output logic              wr_grant,
    output logic              frame_start,
    output logic [LINE_W-1:0] line_no
);

    cmd_e              cmd;
    logic [ADDR_W-1:0] row;
    logic [BANK_W-1:0] bank;
    pins_t             pins;

    scan_rd_fsm #(
        .ACTIVE_W(ACTIVE_W), .VIS_LINES(VIS_LINES), .BLANK_LINES(BLANK_LINES),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .N_REF(N_REF),
        .ADDR_W(ADDR_W), .BANK_W(BANK_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .base_row(base_row), .wr_ack(wr_ack),
        .cmd(cmd), .row(row), .bank(bank), .grant(wr_grant), .dqm(sd_dqm),
        .frame_start(frame_start), .line_no(line_no)
    );

    scan_rd_den #(.ACTIVE_W(ACTIVE_W), .CAS_LAT(CAS_LAT)) u_den (
        .clk(clk), .rst(rst), .rd_pulse(cmd == C_RD), .den(pnl_den)
    );

    scan_rd_enc #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_enc (
        .cmd(cmd), .row(row), .bank(bank), .pins(pins), .addr(sd_addr), .ba(sd_ba)
    );

    assign sd_cke   = 1'b1;
    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

    // window counters used only by the assertions below
    localparam int RUN_W = $clog2(ACTIVE_W + 1) + 1;
    logic [3:0]       rd_age;
    logic [RUN_W-1:0] den_run;
    logic             pin_rd;
    assign pin_rd = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0101);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_age  <= 4'hF;
            den_run <= '0;
        end else begin
            if (pin_rd)              rd_age <= '0;
            else if (rd_age != 4'hF) rd_age <= rd_age + 1'b1;
            den_run <= pnl_den ? den_run + 1'b1 : '0;
        end
    end

    a_r3_den_after_read: assert property (@(posedge clk) disable iff (rst)
        $rose(pnl_den) |-> (rd_age == 4'(CAS_LAT - 1)));

    a_r3_den_width: assert property (@(posedge clk) disable iff (rst)
        $fell(pnl_den) |-> (den_run == RUN_W'(ACTIVE_W)));

    a_r8_window_quiet: assert property (@(posedge clk) disable iff (rst)
        wr_grant |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111) && sd_dqm && !pnl_den);

    a_r10_frame_on_act: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (line_no == '0) && ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011));

    a_r1_cke_high: assert property (@(posedge clk) sd_cke);

endmodule

// File: tb/scan_rd_seq_bench.sv
`timescale 1ns/1ps
module scan_rd_seq_bench;
    import scan_rd_pkg::*;

    localparam int W    = 8;
    localparam int VIS  = 3;
    localparam int BLK  = 2;
    localparam int CL   = 2;
    localparam int RCD  = 2;
    localparam int RP   = 2;
    localparam int RFC  = 3;
    localparam int NREF = 4;
    localparam int AW   = 11;
    localparam int BW   = 2;
    localparam int PGW  = AW + BW;
    localparam int LW   = $clog2(VIS + 1);
    localparam int LINE = line_cycles(W, RCD, RP, RFC, NREF);
    localparam int BCYC = BLK * LINE;
    localparam int RD   = RCD;
    localparam int R0   = RCD + W + 1 + RP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PGW-1:0] base_row = 13'd5;
    logic wr_ack = 1'b0;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm;
    logic [AW-1:0] sd_addr;
    logic [BW-1:0] sd_ba;
    logic pnl_den, wr_grant, frame_start;
    logic [LW-1:0] line_no;

    always #2.5 clk = ~clk;

    scan_rd_seq #(
        .ACTIVE_W(W), .VIS_LINES(VIS), .BLANK_LINES(BLK), .CAS_LAT(CL),
        .T_RCD(RCD), .T_RP(RP), .T_RFC(RFC), .N_REF(NREF), .ADDR_W(AW), .BANK_W(BW)
    ) u_scan_rd_seq (
        .clk(clk), .rst(rst), .base_row(base_row), .wr_ack(wr_ack),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .pnl_den(pnl_den), .wr_grant(wr_grant), .frame_start(frame_start), .line_no(line_no)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference model: 0 visible, 1 blank window, 2 reclaim
    int m_mode = 0, m_ln = 0, m_p = 0, m_q = 0;
    logic [PGW-1:0] m_base = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_ln = 0; m_p = 0; m_base = base_row;
        end else begin
            case (m_mode)
                0: if (m_p == LINE - 1) begin
                       m_p = 0;
                       if (m_ln == VIS - 1) begin m_mode = 1; m_q = 0; end
                       else m_ln = m_ln + 1;
                   end else m_p = m_p + 1;
                1: if (m_q == BCYC - 1) m_mode = 2; else m_q = m_q + 1;
                default: if (!wr_ack) begin
                       m_mode = 0; m_ln = 0; m_p = 0; m_base = base_row;
                   end
            endcase
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [3:0] e_cmd;
            logic [AW-1:0] e_addr;
            logic [BW-1:0] e_ba;
            logic [PGW-1:0] pg;
            logic e_den, e_grant, e_fs, e_dqm;
            int e_line;
            string tg;
            pg = m_base + PGW'(m_ln);
            e_cmd = 4'b0111; e_addr = '0; e_ba = '0; e_den = 0; tg = "R1 nop";
            e_grant = 0; e_fs = 0; e_dqm = 0; e_line = m_ln;
            if (rst) begin
                e_dqm = 1; tg = "R1 reset"; e_line = -1;
            end else if (m_mode == 0) begin
                if (m_p == 0) begin
                    e_cmd = 4'b0011; e_addr = pg[AW-1:0]; e_ba = pg[PGW-1:AW];
                    tg = "R2 R6 R7 activate"; e_fs = (m_ln == 0);
                end else if (m_p == RD) begin
                    e_cmd = 4'b0101; e_ba = pg[PGW-1:AW]; tg = "R2 read";
                end else if (m_p == RD + W) begin
                    e_cmd = 4'b0110; tg = "R4 burst stop";
                end else if (m_p == RD + W + 1) begin
                    e_cmd = 4'b0010; e_addr = AW'(1 << 10); e_ba = pg[PGW-1:AW];
                    tg = "R4 precharge";
                end else if (m_p >= R0 && ((m_p - R0) % RFC) == 0) begin
                    e_cmd = 4'b0001; tg = "R5 refresh";
                end else if (m_p >= R0) begin
                    tg = "R5 refresh gap";
                end
                e_den = (m_p >= RD + CL) && (m_p <= RD + CL + W - 1);
            end else if (m_mode == 1) begin
                e_grant = 1; e_dqm = 1; e_line = VIS; tg = "R8 window";
            end else begin
                e_dqm = 1; e_line = VIS; tg = "R9 reclaim";
            end
            chk({tg, " cmd"}, {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, e_cmd});
            chk({tg, " addr"}, 32'(sd_addr), 32'(e_addr));
            chk({tg, " ba"}, 32'(sd_ba), 32'(e_ba));
            chk({tg, " R3 den"}, 32'(pnl_den), 32'(e_den));
            chk({tg, " R8 grant"}, 32'(wr_grant), 32'(e_grant));
            chk({tg, " dqm"}, 32'(sd_dqm), 32'(e_dqm));
            chk({tg, " R10 frame_start"}, 32'(frame_start), 32'(e_fs));
            chk("R1 cke", 32'(sd_cke), 32'd1);
            if (e_line >= 0) chk({tg, " R10 line_no"}, 32'(line_no), 32'(e_line));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [PGW-1:0] bases [8];
        bases = '{13'd100, 13'd8190, 13'd0, 13'd2047, 13'd4094, 13'd8191, 13'd1, 13'd6143};
        repeat (4) @(negedge clk);
        rst = 0;
        // R7: a mid-frame base change must not alter this frame's rows
        repeat (30) @(negedge clk);
        base_row = 13'd77;
        for (int k = 0; k < 8; k++) begin
            do @(negedge clk); while (!wr_grant);
            // R9: ack pulse inside the window has no effect
            repeat (5) @(negedge clk);
            wr_ack = 1;
            @(negedge clk);
            wr_ack = (k % 2 == 0);
            repeat (10) @(negedge clk);
            wr_ack = 1;
            do @(negedge clk); while (wr_grant);
            // R7: base set in the reclaim cycle applies to the next frame
            base_row = bases[k];
            repeat (k % 4) @(negedge clk);
            wr_ack = 0;
            // R7: change in the frame_start cycle is too late for this frame
            do @(negedge clk); while (!frame_start);
            if (k == 3) base_row = 13'd999;
        end
        // R1: reset mid-frame returns to the reset state
        repeat (40) @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (2 * (VIS * LINE + BCYC)) @(negedge clk);
        finish_run();
    end

endmodule